// File: doc/BRIEF.md
# I2C Master Command and Byte Engine

This block is a register-driven I2C master that performs one bus action at a time: a START, a repeated START, a STOP, or the transmission of one byte followed by sampling of the acknowledge bit. Software writes a control word to request a bus condition, or a data word to send a byte. It then waits until the busy flag clears, or waits for an interrupt. The engine drives open-drain enables for SCL and SDA. A separate input returns the resolved SDA level. The SCL period is a fixed number of clock cycles set by a parameter.

A status word holds sticky completion, NAK and error flags that are cleared by writing 1. A mask word selects which of these flags drive the single interrupt output. The I2C address byte has no special status: it is sent through the data word like any other byte, so its direction bit is an ordinary data bit.

Every register access completes in the cycle it is presented, and the block applies no back-pressure at its register port. Software must instead respect the busy flag. A control or data write that arrives while busy is high is dropped and is recorded as an error.

Top module: `i2c_cmd_byte_engine`

## Requirements
- R1: After reset both line enables are deasserted, the control word (address 0), the status word (address 2) and the mask word (address 3) read 0, and the interrupt is low.
- R2: A control write with bit 0 (enable) set, bits 2:1 equal to 1 and bit 3 equal to 0 produces a START: with SCL high, SDA falls, and then SCL is pulled low.
- R3: A control write with enable set, bits 2:1 equal to 1 and bit 3 equal to 1 produces a repeated START: SDA is released, then SCL is released, then SDA falls while SCL is high, then SCL is pulled low.
- R4: A control write with enable set and bits 2:1 equal to 2 produces a STOP: SDA rises while SCL is high, and both line enables are deasserted afterwards.
- R5: A write to the data word (address 1) while enabled sends bits 7:0 MSB first on eight SCL pulses and releases SDA for a ninth pulse. SDA changes only while SCL is low, and bit 0 is treated like every other bit.
- R6: After a byte completes, control bit 3 reads 1 if SDA was high at the ninth pulse (NAK) and 0 if it was low (ACK). A NAK also sets status bit 0.
- R7: Status bit 7 (busy) is 1 from the cycle after an accepted command or data write until the bus action ends. At that end, status bit 3 (done) is set.
- R8: A control or data write while busy is ignored: it causes no bus activity and no change to the control word. It sets status bit 2 (error).
- R9: Writing 1 to status bits 0, 2 or 3 clears them. Writing to bit 7 or to the reserved bits 6 and 5 has no effect, and those reserved bits read 0.
- R10: The interrupt is high exactly when a status bit among 4, 3, 1 and 0 is set together with the matching bit of the mask word. With the mask at 0, the interrupt is low.
- R11: While the enable bit is 0, both line enables are deasserted, and control and data writes start no bus action.
- R12: A control write with bits 2:1 equal to 0 or 3 starts no bus action and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Word address: 0 control, 1 data, 2 status, 3 interrupt mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational; the data word reads 0) |
| sda_in | input | 1 | Resolved SDA level from the pad |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| irq | output | 1 | Interrupt, high while an enabled status bit is set |

## Verification
The most awkward case to reach from the ports is the acknowledge slot. The engine must release SDA and then sample a level that only the far side controls. The bench therefore contains a slave model that decodes SCL and SDA edges into START, repeated START, STOP and byte events. That model pulls SDA low on the ninth pulse when the test asks for an ACK, and leaves it high when the test asks for a NAK. A second hard case is a write that collides with a busy engine. The driver issues that write in the cycle right after a command is accepted. The scoreboard then shows that no extra bus event appears, while the status word shows the error flag.

// File: rtl/icb_pkg.sv
package icb_pkg;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_RESTART = 2'd1,
    OP_STOP    = 2'd2,
    OP_BYTE    = 2'd3
  } icb_op_e;

  // register word addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_IEN  = 2'd3;

  // command field codes
  localparam logic [1:0] CMD_COND = 2'd1;
  localparam logic [1:0] CMD_STOP = 2'd2;

  // status bit positions, decoded by software
  localparam int ST_NAK  = 0;
  localparam int ST_FIFO = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_DONE = 3;
  localparam int ST_RDC  = 4;
  localparam int ST_BUSY = 7;

  localparam logic [7:0] IEN_MASK = 8'h1B;

endpackage

// File: rtl/icb_bus_seq.sv
module icb_bus_seq
  import icb_pkg::*;
#(
  parameter int QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       launch,
  input  icb_op_e    launch_op,
  input  logic [7:0] launch_byte,
  input  logic       sda_in,
  output logic       busy,
  output logic       done,
  output logic       byte_done,
  output logic       nak,
  output logic       scl_low,
  output logic       sda_low
);

  localparam int BYTE_STEPS = 36;
  localparam int STEP_W     = $clog2(BYTE_STEPS);
  localparam int TICK_W     = $clog2(QTR + 1);
  localparam int ACK_STEP   = 8 * 4 + 2;

  logic              active;
  icb_op_e           op_q;
  logic [7:0]        shreg;
  logic [STEP_W-1:0] step;
  logic [TICK_W-1:0] tick;
  logic              ack_smp;
  logic              rest_scl, rest_sda;
  logic              done_q, byte_done_q, nak_q;
  logic              scl_low_q, sda_low_q;

  logic [STEP_W-1:0] last_step;
  logic [STEP_W-3:0] bit_idx;
  logic [1:0]        qtr_idx;
  logic              tick_end, step_end_last;
  logic              tbl_scl, tbl_sda;
  logic              nxt_rest_scl, nxt_rest_sda;

  assign bit_idx       = step[STEP_W-1:2];
  assign qtr_idx       = step[1:0];
  assign tick_end      = (tick == TICK_W'(QTR - 1));
  assign step_end_last = active && tick_end && (step == last_step);

  always_comb begin
    last_step    = STEP_W'(BYTE_STEPS - 1);
    tbl_scl      = 1'b0;
    tbl_sda      = 1'b0;
    nxt_rest_scl = 1'b1;
    nxt_rest_sda = 1'b1;
    case (op_q)
      OP_START: begin
        last_step = STEP_W'(2);
        tbl_scl   = (step == STEP_W'(2));
        tbl_sda   = (step != STEP_W'(0));
      end
      OP_RESTART: begin
        last_step = STEP_W'(3);
        tbl_scl   = (step == STEP_W'(0)) || (step == STEP_W'(3));
        tbl_sda   = (step >= STEP_W'(2));
      end
      OP_STOP: begin
        last_step    = STEP_W'(2);
        tbl_scl      = (step == STEP_W'(0));
        tbl_sda      = (step != STEP_W'(2));
        nxt_rest_scl = 1'b0;
        nxt_rest_sda = 1'b0;
      end
      default: begin
        last_step    = STEP_W'(BYTE_STEPS - 1);
        tbl_scl      = !qtr_idx[1];
        tbl_sda      = (bit_idx < (STEP_W-2)'(8)) ? !shreg[7] : 1'b0;
        nxt_rest_sda = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      op_q        <= OP_START;
      shreg       <= '0;
      step        <= '0;
      tick        <= '0;
      ack_smp     <= 1'b1;
      rest_scl    <= 1'b0;
      rest_sda    <= 1'b0;
      done_q      <= 1'b0;
      byte_done_q <= 1'b0;
      nak_q       <= 1'b0;
    end else begin
      done_q      <= 1'b0;
      byte_done_q <= 1'b0;
      if (!active) begin
        if (launch) begin
          active <= 1'b1;
          op_q   <= launch_op;
          shreg  <= launch_byte;
          step   <= '0;
          tick   <= '0;
        end
      end else if (tick_end) begin
        tick <= '0;
        if (op_q == OP_BYTE && step == STEP_W'(ACK_STEP))
          ack_smp <= sda_in;
        if (op_q == OP_BYTE && qtr_idx == 2'd3)
          shreg <= {shreg[6:0], 1'b0};
        if (step_end_last) begin
          active      <= 1'b0;
          done_q      <= 1'b1;
          byte_done_q <= (op_q == OP_BYTE);
          nak_q       <= (op_q == OP_BYTE) && ack_smp;
          rest_scl    <= nxt_rest_scl;
          rest_sda    <= nxt_rest_sda;
        end else begin
          step <= step + STEP_W'(1);
        end
      end else begin
        tick <= tick + TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      scl_low_q <= en && (active ? tbl_scl : rest_scl);
      sda_low_q <= en && (active ? tbl_sda : rest_sda);
    end
  end

  assign busy      = active;
  assign done      = done_q;
  assign byte_done = byte_done_q;
  assign nak       = nak_q;
  assign scl_low   = scl_low_q;
  assign sda_low   = sda_low_q;

  // R7: an accepted launch makes the engine busy on the next cycle
  a_r7_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !active) |=> active);

  // R7: completion is reported only once the engine is idle again
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !active);

  // R5: SDA stays put while SCL is high inside a byte
  a_r5_sda_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && op_q == OP_BYTE && !scl_low_q && $past(!scl_low_q))
      |-> $stable(sda_low_q));

  // R11: lines are released whenever the block is disabled
  a_r11_lines_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_low_q && !sda_low_q));

  // R4: a finished stop leaves both lines released
  a_r4_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_q == OP_STOP) |-> (!scl_low_q && !sda_low_q));

endmodule

// File: rtl/icb_status.sv
module icb_status
  import icb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       set_done,
  input  logic       set_nak,
  input  logic       set_err,
  input  logic       clr_we,
  input  logic [7:0] clr_bits,
  input  logic       ien_we,
  input  logic [7:0] ien_bits,
  output logic [7:0] status_word,
  output logic [7:0] ien_word,
  output logic       irq
);

  logic st_nak, st_err, st_done;
  logic [7:0] ien_q;
  logic unused_clr, unused_ien;

  assign unused_clr = ^{clr_bits[7:4], clr_bits[1]};
  assign unused_ien = ^{ien_bits[7:5], ien_bits[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_nak  <= 1'b0;
      st_err  <= 1'b0;
      st_done <= 1'b0;
      ien_q   <= '0;
    end else begin
      // set wins over a same-cycle clear
      if (set_nak)
        st_nak <= 1'b1;
      else if (clr_we && clr_bits[ST_NAK])
        st_nak <= 1'b0;
      if (set_err)
        st_err <= 1'b1;
      else if (clr_we && clr_bits[ST_ERR])
        st_err <= 1'b0;
      if (set_done)
        st_done <= 1'b1;
      else if (clr_we && clr_bits[ST_DONE])
        st_done <= 1'b0;
      if (ien_we)
        ien_q <= ien_bits & IEN_MASK;
    end
  end

  always_comb begin
    status_word          = '0;
    status_word[ST_BUSY] = busy;
    status_word[ST_DONE] = st_done;
    status_word[ST_ERR]  = st_err;
    status_word[ST_NAK]  = st_nak;
  end

  assign ien_word = ien_q;
  assign irq      = |(status_word & ien_q & IEN_MASK);

endmodule

// File: rtl/i2c_cmd_byte_engine.sv
module i2c_cmd_byte_engine
  import icb_pkg::*;
#(
  parameter int SCL_PERIOD = 16,
  parameter int REG_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sda_in,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  output logic             irq
);

  localparam int QTR = (SCL_PERIOD / 4 < 2) ? 2 : SCL_PERIOD / 4;

  logic       en_q;
  logic [1:0] cmd_q;
  logic       nak_flag;

  logic       wr_ctrl, wr_data, wr_stat, wr_ien;
  logic       blocked, launch;
  icb_op_e    launch_op;
  logic [1:0] wcmd;

  logic       seq_busy, seq_done, seq_byte_done, seq_nak;
  logic [7:0] stat_word, ien_word;
  logic       unused_wbits;

  assign unused_wbits = ^reg_wdata[REG_W-1:8];

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_ien  = reg_wr && (reg_addr == ADDR_IEN);
  assign wcmd    = reg_wdata[2:1];

  assign blocked = seq_busy && (wr_ctrl || wr_data);

  always_comb begin
    launch    = 1'b0;
    launch_op = OP_BYTE;
    if (!seq_busy) begin
      if (wr_ctrl && reg_wdata[0]) begin
        if (wcmd == CMD_COND) begin
          launch    = 1'b1;
          launch_op = reg_wdata[3] ? OP_RESTART : OP_START;
        end else if (wcmd == CMD_STOP) begin
          launch    = 1'b1;
          launch_op = OP_STOP;
        end
      end else if (wr_data && en_q) begin
        launch    = 1'b1;
        launch_op = OP_BYTE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      cmd_q    <= '0;
      nak_flag <= 1'b0;
    end else begin
      if (wr_ctrl && !seq_busy) begin
        en_q  <= reg_wdata[0];
        cmd_q <= wcmd;
      end
      if (seq_byte_done)
        nak_flag <= seq_nak;
    end
  end

  icb_bus_seq #(.QTR(QTR)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en_q),
    .launch      (launch),
    .launch_op   (launch_op),
    .launch_byte (reg_wdata[7:0]),
    .sda_in      (sda_in),
    .busy        (seq_busy),
    .done        (seq_done),
    .byte_done   (seq_byte_done),
    .nak         (seq_nak),
    .scl_low     (scl_drive_low),
    .sda_low     (sda_drive_low)
  );

  icb_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (seq_busy),
    .set_done    (seq_done),
    .set_nak     (seq_byte_done && seq_nak),
    .set_err     (blocked),
    .clr_we      (wr_stat),
    .clr_bits    (reg_wdata[7:0]),
    .ien_we      (wr_ien),
    .ien_bits    (reg_wdata[7:0]),
    .status_word (stat_word),
    .ien_word    (ien_word),
    .irq         (irq)
  );

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {{(REG_W-4){1'b0}}, nak_flag, cmd_q, en_q};
      ADDR_STAT: reg_rdata = {{(REG_W-8){1'b0}}, stat_word};
      ADDR_IEN:  reg_rdata = {{(REG_W-8){1'b0}}, ien_word};
      default:   reg_rdata = '0;
    endcase
  end

  // R8: a write colliding with a busy engine is flagged as an error
  a_r8_busy_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> stat_word[ST_ERR]);

  // R9: write-one clears the done flag when no completion collides
  a_r9_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[ST_DONE] && !seq_done) |=> !stat_word[ST_DONE]);

  // R9: reserved status positions stay zero
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[6:5] == 2'b00));

endmodule

// File: tb/i2c_cmd_byte_engine_tb.sv
`timescale 1ns/1ps
module i2c_cmd_byte_engine_tb;

  localparam int EV_START   = 256;
  localparam int EV_RESTART = 257;
  localparam int EV_STOP    = 258;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        scl_drive_low, sda_drive_low, irq;
  logic        slave_pull = 1'b0;
  logic        ack_next = 1'b1;
  logic        sda_line, scl_line;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  assign sda_line = !(sda_drive_low || slave_pull);
  assign scl_line = !scl_drive_low;

  i2c_cmd_byte_engine u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .sda_in        (sda_line),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .irq           (irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: slave model decoding bus events and comparing with the scoreboard
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  logic       bus_idle = 1'b1;
  int         bitcnt = 0;
  logic [7:0] shv = '0;

  task automatic see_event(input int code);
    int    expv;
    string req;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R5 unexpected bus event", code, -1);
    end else begin
      expv = exp_q.pop_front();
      req = (expv == EV_START) ? "R2" : (expv == EV_RESTART) ? "R3" :
            (expv == EV_STOP) ? "R4" : "R5";
      chk(code == expv, req, code, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line && prev_scl && prev_sda && !sda_line) begin
        see_event(bus_idle ? EV_START : EV_RESTART);
        bus_idle = 1'b0;
        bitcnt = 0;
      end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
        see_event(EV_STOP);
        bus_idle = 1'b1;
        bitcnt = 0;
      end else if (scl_line && !prev_scl) begin
        if (bitcnt < 8) shv = {shv[6:0], sda_line};
        bitcnt++;
        if (bitcnt == 8) see_event(int'(shv));
        if (bitcnt == 9) bitcnt = 0;
      end else if (!scl_line && prev_scl) begin
        slave_pull = (bitcnt == 8) ? ack_next : 1'b0;
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    reg_read(2'd2, d);
    for (int i = 0; i < 5000 && d[7]; i++) reg_read(2'd2, d);
    chk(d[7] == 1'b0, "R7 busy clears", int'(d[7]), 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack);
    ack_next = ack;
    exp_q.push_back(int'(b));
    reg_write(2'd1, {24'd0, b});
    wait_idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    reg_read(2'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    reg_read(2'd2, d); chk(d == 0, "R1 status", d, 0);
    reg_read(2'd3, d); chk(d == 0, "R1 mask", d, 0);
    chk(!irq && !scl_drive_low && !sda_drive_low, "R1 lines",
        {irq, scl_drive_low, sda_drive_low}, 0);

    // R11: disabled block ignores data and command writes
    reg_write(2'd1, 32'h77);
    reg_write(2'd0, 32'h2);
    repeat (20) @(negedge clk);
    reg_read(2'd2, d); chk(d == 0, "R11 no busy", d, 0);
    chk(!scl_drive_low && !sda_drive_low, "R11 lines released",
        {scl_drive_low, sda_drive_low}, 0);

    // R12: command codes 0 and 3 do nothing
    reg_write(2'd0, 32'h1);
    reg_read(2'd2, d); chk(d[7] == 0, "R12 cmd0 idle", d, 0);
    reg_write(2'd0, 32'h7);
    reg_read(2'd2, d); chk(d[7] == 0, "R12 cmd3 idle", d, 0);
    repeat (20) @(negedge clk);
    chk(!scl_drive_low && !sda_drive_low, "R12 lines", {scl_drive_low, sda_drive_low}, 0);

    // R10 mask: session done only
    reg_write(2'd3, 32'h08);

    // R2 START, R7 busy, R8 collision
    exp_q.push_back(EV_START);
    reg_write(2'd0, 32'h3);
    reg_read(2'd2, d); chk(d[7] == 1, "R7 busy set", d[7], 1);
    reg_write(2'd1, 32'h55);
    reg_write(2'd0, 32'h5);
    reg_read(2'd2, d); chk(d[2] == 1, "R8 error set", d[2], 1);
    reg_read(2'd0, d); chk(d[2:0] == 3'b011, "R8 ctrl unchanged", d[2:0], 3);
    wait_idle();
    reg_read(2'd2, d); chk(d[3] == 1, "R7 done set", d[3], 1);
    chk(irq == 1, "R10 irq on done", irq, 1);

    // R9: reserved and busy writes no effect, W1C clears
    reg_write(2'd2, 32'hE0);
    reg_read(2'd2, d); chk(d[7:0] == 8'h0C, "R9 no-op write", d, 8'h0C);
    reg_write(2'd2, 32'h0C);
    reg_read(2'd2, d); chk(d == 0, "R9 cleared", d, 0);
    chk(irq == 0, "R10 irq off after clear", irq, 0);

    // R5 / R6 byte with ACK
    send_byte(8'hA5, 1'b1);
    reg_read(2'd0, d); chk(d[3] == 0, "R6 ack readback", d[3], 0);
    reg_read(2'd2, d); chk(d[0] == 0, "R6 no nak status", d[0], 0);

    // R6 byte with NAK
    send_byte(8'h3C, 1'b0);
    reg_read(2'd0, d); chk(d[3] == 1, "R6 nak readback", d[3], 1);
    reg_read(2'd2, d); chk(d[0] == 1, "R6 nak status", d[0], 1);
    reg_write(2'd3, 32'h01);
    #1 chk(irq == 1, "R10 irq on nak", irq, 1);
    reg_write(2'd3, 32'h00);
    #1 chk(irq == 0, "R10 mask zero", irq, 0);
    reg_write(2'd2, 32'h0D);

    // R5: address-style byte, bit 0 ordinary
    send_byte(8'h01, 1'b1);
    reg_read(2'd0, d); chk(d[3] == 0, "R6 ack after nak", d[3], 0);

    // R3 repeated start then byte and R4 stop
    exp_q.push_back(EV_RESTART);
    reg_write(2'd0, 32'hB);
    wait_idle();
    send_byte(8'h80, 1'b1);
    exp_q.push_back(EV_STOP);
    reg_write(2'd0, 32'h5);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(!scl_drive_low && !sda_drive_low, "R4 released after stop",
        {scl_drive_low, sda_drive_low}, 0);

    // R2 again from idle, then stop
    exp_q.push_back(EV_START);
    reg_write(2'd0, 32'h3);
    wait_idle();
    send_byte(8'hFE, 1'b0);
    exp_q.push_back(EV_STOP);
    reg_write(2'd0, 32'h5);
    wait_idle();

    // R11: disable
    reg_write(2'd0, 32'h0);
    repeat (4) @(negedge clk);
    chk(!scl_drive_low && !sda_drive_low, "R11 disabled lines",
        {scl_drive_low, sda_drive_low}, 0);

    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all events seen", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule